// File: doc/BRIEF.md
# Video Field and Interlace Detector

This block sits after a video sync separator. It takes two inputs: a horizontal line clock whose level marks the first and second half of each line, and a separated vertical-sync pulse. From these it decides whether the picture is interlaced, and it produces a field indicator that downstream line counters use to start and restart their counts.

At each vertical-sync rising edge the block captures the level of the line clock. Progressive video always starts vertical sync in the high half of a line, so the capture is high on every field. Interlaced video starts vertical sync half a line later on alternate fields, so the capture alternates. Each change in the capture puts the block in interlaced mode and restarts a timeout. The timeout counts line-clock rising edges. If no change arrives before it expires, the block returns to progressive mode.

In interlaced mode the field indicator follows the capture, which is high for field 1. In progressive mode the field indicator comes from a flip-flop that toggles on every vertical-sync edge, so the counters are re-armed on every field. The mode flag is an output that a host can read. Both inputs pass through a synchronizer whose depth is a parameter.

Top module: `fid_detector`

## Requirements
- R1: After reset, `field_o` and `interlaced_o` are both low.
- R2: On each vertical-sync rising edge the block captures the line-clock level present at that edge. A capture that differs from the previous one sets `interlaced_o` by the next check point.
- R3: `interlaced_o` stays high while each capture differs from the one before it and changes keep arriving within the timeout window. Each change restarts the timeout count at zero.
- R4: The block counts line-clock rising edges that occur after the last capture change. When this count reaches `TIMEOUT_LINES`, `interlaced_o` goes low. At `TIMEOUT_LINES - 1` it is still high.
- R5: While `interlaced_o` is high, `field_o` equals the latest capture: 1 means vertical sync rose in the high half of a line (field 1), and 0 means it rose in the low half (field 2).
- R6: While `interlaced_o` is low, `field_o` is a flip-flop that inverts on every vertical-sync rising edge. It starts at 0 after reset.
- R7: Progressive video, whose vertical sync always rises in the high half of a line, never sets `interlaced_o`.
- R8: Line-clock edges, vertical-sync falling edges and a held-high vertical sync leave `field_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_clk_i | input | 1 | Horizontal line clock level (high in the first half of each line) |
| vsync_i | input | 1 | Separated vertical sync, active high |
| field_o | output | 1 | Field indicator: 1 for field 1, 0 for field 2 |
| interlaced_o | output | 1 | Interlaced mode flag for the host |

## Verification
The bench probes the boundary of the timeout window. It stops the alternation in interlaced mode and checks the flag on every line. An off-by-one counter would drop the flag one line early or one line late. Runs of progressive video that start with the capture already high show whether a design treats the reset value as a change, which would wrongly report interlace. Random mixes of progressive, interlaced and random-phase segments test the hand-over between the sample-driven and toggle-driven field sources. A design that froze its toggle flip-flop during interlaced mode would show the wrong field parity after falling back.

// File: rtl/fid_pkg.sv
package fid_pkg;
   typedef enum logic {
      SCAN_PROG = 1'b0,
      SCAN_INTL = 1'b1
   } scan_mode_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/fid_sync.sv
module fid_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign q_o = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/fid_phase.sv
module fid_phase (
   input  logic clk,
   input  logic rst_n,
   input  logic line_lvl_i,
   input  logic vs_lvl_i,
   output logic sample_o,
   output logic flip_o,
   output logic change_o,
   output logic line_rise_o
);
   logic vs_q, line_q, vs_rise;

   assign vs_rise     = vs_lvl_i & ~vs_q;
   assign line_rise_o = line_lvl_i & ~line_q;
   assign change_o    = vs_rise & (line_lvl_i != sample_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_q     <= 1'b0;
         line_q   <= 1'b0;
         sample_o <= 1'b1;
         flip_o   <= 1'b0;
      end else begin
         vs_q   <= vs_lvl_i;
         line_q <= line_lvl_i;
         if (vs_rise) begin
            sample_o <= line_lvl_i;
            flip_o   <= ~flip_o;
         end
      end
   end

   AST_FLIP_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      vs_rise |=> (flip_o != $past(flip_o)));                     // R6
   AST_CAPTURE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      vs_rise |=> (sample_o == $past(line_lvl_i)));               // R2
   AST_HOLD_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !vs_rise |=> ($stable(sample_o) && $stable(flip_o)));       // R8
endmodule

// File: rtl/fid_timeout.sv
module fid_timeout #(
   parameter int unsigned LIMIT = 700,
   parameter int unsigned CW    = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload_i,
   input  logic tick_i,
   output logic expired_o
);
   logic [CW-1:0] cnt_q;
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= LIM;
      else if (reload_i)             cnt_q <= '0;
      else if (tick_i && cnt_q < LIM) cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = (cnt_q == LIM);

   AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reload_i |=> (cnt_q == '0));                                // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (expired_o && !reload_i) |=> expired_o);                    // R4
endmodule

// File: rtl/fid_detector.sv
module fid_detector #(
   parameter int unsigned TIMEOUT_LINES = 700,
   parameter int          SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_clk_i,
   input  logic vsync_i,
   output logic field_o,
   output logic interlaced_o
);
   import fid_pkg::*;

   localparam int unsigned CW = cnt_width(TIMEOUT_LINES);

   generate
      if (TIMEOUT_LINES < 2) begin : g_bad_timeout
         $error("TIMEOUT_LINES must be at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be within 0..4");
      end
   endgenerate

   logic [1:0] raw_in, synced;
   logic       sample, flip, change, line_rise, expired;
   scan_mode_e mode_q;

   assign raw_in = {vsync_i, line_clk_i};

   fid_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(synced));

   fid_phase u_phase (
      .clk(clk), .rst_n(rst_n),
      .line_lvl_i(synced[0]), .vs_lvl_i(synced[1]),
      .sample_o(sample), .flip_o(flip),
      .change_o(change), .line_rise_o(line_rise));

   fid_timeout #(.LIMIT(TIMEOUT_LINES), .CW(CW)) u_timeout (
      .clk(clk), .rst_n(rst_n),
      .reload_i(change), .tick_i(line_rise), .expired_o(expired));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q <= SCAN_PROG;
      else if (change)  mode_q <= SCAN_INTL;
      else if (expired) mode_q <= SCAN_PROG;
   end

   assign interlaced_o = (mode_q == SCAN_INTL);
   assign field_o      = interlaced_o ? sample : flip;

   AST_ENTER_INTL: assert property (@(posedge clk) disable iff (!rst_n)
      change |=> interlaced_o);                                   // R3
   AST_LEAVE_INTL: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !change) |=> !interlaced_o);                    // R4
   AST_PROG_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (!interlaced_o && !change) |=> !interlaced_o);              // R7
endmodule

// File: tb/sim_fid_detector.sv
module sim_fid_detector;
   localparam int T = 24;

   logic clk = 1'b0, rst_n = 1'b0, line_clk = 1'b0, vsync = 1'b0;
   logic field, intl;
   int vectors = 0, errors = 0;
   int m_cnt;
   bit m_s, m_flip, m_il, prog_only;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fid_detector #(.TIMEOUT_LINES(T), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .line_clk_i(line_clk), .vsync_i(vsync),
      .field_o(field), .interlaced_o(intl));

   function automatic bit exp_field(bit il, bit s, bit f);
      return il ? s : f;
   endfunction

   task automatic check(string tag, string what, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
      end
   endtask

   task automatic model_line_rise();
      if (m_cnt < T) m_cnt++;
      if (m_cnt == T) m_il = 1'b0;
   endtask

   task automatic model_vsync(bit lvl);
      if (lvl != m_s) begin m_cnt = 0; m_il = 1'b1; end
      m_s = lvl;
      m_flip = ~m_flip;
   endtask

   // vpos: 0 = no vsync this line, 1 = rises in high half, 2 = rises in low half
   task automatic run_line(int vpos);
      @(negedge clk); vsync = 1'b0; line_clk = 1'b1; model_line_rise();
      repeat (2) @(negedge clk);
      if (vpos == 1) begin vsync = 1'b1; model_vsync(1'b1); end
      repeat (2) @(negedge clk);
      line_clk = 1'b0;
      @(negedge clk);
      if (vpos == 2) begin vsync = 1'b1; model_vsync(1'b0); end
      repeat (8) @(negedge clk);
      check(vpos == 0 ? "R8" : (m_il ? "R5" : "R6"), "field", field,
            exp_field(m_il, m_s, m_flip));
      check(prog_only ? "R7" : (vpos != 0 ? "R2" : (m_il ? "R3" : "R4")),
            "interlaced", intl, m_il);
   endtask

   task automatic run_field(int vpos, int lines);
      run_line(vpos);
      for (int i = 1; i < lines; i++) run_line(0);
   endtask

   initial begin
      void'($urandom(32'h5eed_f1d0));
      m_cnt = T; m_s = 1'b1; m_flip = 1'b0; m_il = 1'b0; prog_only = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", "field", field, 1'b0);
      check("R1", "interlaced", intl, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", "field", field, 1'b0);
      check("R1", "interlaced", intl, 1'b0);

      // R7: progressive fields, longer than the timeout in total
      prog_only = 1'b1;
      for (int f = 0; f < 8; f++) run_field(1, 7);
      prog_only = 1'b0;

      // R3/R5: interlaced fields
      for (int f = 0; f < 6; f++) run_field((f % 2) ? 1 : 2, 9);

      // R4 boundary: stop alternating, run past the window line by line
      run_field(1, T + 3);
      check("R4", "interlaced after window", intl, 1'b0);

      // R8: vsync held high across lines does nothing
      run_line(1);
      @(negedge clk); line_clk = 1'b1; model_line_rise();
      repeat (5) @(negedge clk); line_clk = 1'b0;
      repeat (5) @(negedge clk);
      check("R8", "field with vsync held", field, exp_field(m_il, m_s, m_flip));
      vsync = 1'b0;
      repeat (5) @(negedge clk);
      check("R8", "field after vsync fall", field, exp_field(m_il, m_s, m_flip));

      // random segments
      for (int seg = 0; seg < 24; seg++) begin
         int kind = int'($urandom_range(0, 2));
         int nf   = int'($urandom_range(2, 6));
         for (int f = 0; f < nf; f++) begin
            int vp;
            case (kind)
               0: vp = 1;
               1: vp = (f % 2) ? 1 : 2;
               default: vp = int'($urandom_range(1, 2));
            endcase
            run_field(vp, int'($urandom_range(3, 14)));
         end
      end
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule